// File: doc/BRIEF.md
# Per-Pin Vector Timing Formatter

This block drives and checks one digital tester pin from a stream of test vectors. Each vector names a waveform table and a character code. The block looks up the pair once, at the start of the period. The result is an action plus three tick offsets: a data edge, a return edge and a compare strobe. A fast timing clock counts ticks across the period, and each offset fires on the tick where the count equals it. Because the lookup happens every period, edge placement can change from one vector to the next. One vector can therefore form a return-to-zero pulse or a full clock cycle.

The block registers the pin value and the output enable. At the strobe it compares the sampled pin against the expected state and emits a per-vector fail flag tagged with the vector's index. A host port fills the tables while no pattern runs. Writes made while a pattern is running, or to an address that does not exist, are refused with an error response.

Top module: `pin_vec_formatter`

## Requirements
- R1: The table entry is selected by a 5-bit table select and a 4-bit character code. Valid selects are below NUM_TBL and valid codes are below NUM_CHR (15). A vector with an invalid select or code behaves as don't-compare with offsets 0 and no return. After reset, every entry holds that same value.
- R2: Entry word layout:
  - bits [2:0] action: 0 force low, 1 force high, 2 force previous, 3 stop forcing, 4 compare low, 5 compare high, 6 compare tri-state, 7 don't compare.
  - bits [4:3] return state: 0 none, 1 low, 2 high, 3 release.
  - then three TW-bit offsets, from low to high: data edge, return edge, strobe.
  
  A write raises `wr_ack` on the next cycle. `wr_err` on that cycle reports an invalid select or code, and the table is then left unchanged.
- R3: While a pattern is active, or while `run` is high, a write gets `wr_err` and leaves the table unchanged.
- R4: `vec_take` is high while `run` is high and either no period is active or the current tick is the last one of the period. In that cycle the presented vector and `period_len` are latched, with a length of 0 treated as 1. Tick 0 follows on the next cycle, so periods run back to back. With `run` low at the last tick, the block goes idle.
- R5: An edge or strobe with offset k acts on tick k. Its effect on `pin_out`/`pin_oe` is visible from tick k+1. Offsets may differ in every period.
- R6: On the data edge:
  - force low/high drives 0/1 with the output enabled;
  - force previous enables the output and keeps the last driven value.
- R7: On the data edge, stop forcing clears `pin_oe` and leaves the driven value unchanged.
- R8: For the four force actions, the return edge applies the return state: low, high, or release. If both edges fall on the same tick, the return state wins. Compare actions drive nothing.
- R9: An offset at or beyond the latched period length never fires.
- R10: At the strobe:
  - compare low fails unless the pin reads 0 and is not high-impedance;
  - compare high fails unless it reads 1 and is not high-impedance;
  - compare tri-state fails unless the pin reads high-impedance;
  - every other action never fails.
- R11: `res_valid` is high for one cycle, on the tick after the strobe. It carries `res_fail` and `res_index`, the vector's position counted from 0 at the first vector after idle.
- R12: After reset, `pin_out`, `pin_oe`, `res_valid`, `wr_ack` and `vec_take` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock, one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host table write strobe |
| wr_tbl | input | 5 | Table select for the write |
| wr_chr | input | 4 | Character code for the write |
| wr_data | input | 5+3*TW | Entry word, layout as in R2 |
| wr_ack | output | 1 | Write response valid |
| wr_err | output | 1 | Write refused |
| run | input | 1 | Pattern run request |
| period_len | input | TW | Period length in ticks, latched at take |
| vec_tbl | input | 5 | Table select of the presented vector |
| vec_chr | input | 4 | Character code of the presented vector |
| vec_take | output | 1 | Presented vector consumed this cycle |
| pin_in | input | 1 | Sampled pin logic value |
| pin_hiz | input | 1 | Pin sampled as high impedance |
| pin_out | output | 1 | Drive value |
| pin_oe | output | 1 | Driver enable |
| res_valid | output | 1 | Result of a vector strobe |
| res_fail | output | 1 | Compare failure for that vector |
| res_index | output | IDX_W | Index of the vector the result belongs to |

## Verification
The bench builds the block with NUM_TBL=4, TW=6 and IDX_W=8. With only four tables, a 5-bit select reaches addresses that do not exist, which exercises the out-of-range lookup and the refused write. The topmost valid table and code are also exercised. Six-bit offsets against periods of 0 to 12 ticks make it easy to place edges and strobes past the period end. Single-tick periods push back-to-back lookups with a strobe on every cycle. The pin is looped back from the driver, and fault injection inverts its value or forces high impedance.

// File: rtl/pvf_pkg.sv
package pvf_pkg;

    localparam int SEL_W  = 5;
    localparam int CODE_W = 4;

    typedef enum logic [2:0] {
        ACT_LO     = 3'd0,
        ACT_HI     = 3'd1,
        ACT_PREV   = 3'd2,
        ACT_OFF    = 3'd3,
        ACT_CMP_LO = 3'd4,
        ACT_CMP_HI = 3'd5,
        ACT_CMP_Z  = 3'd6,
        ACT_SKIP   = 3'd7
    } act_e;

    typedef enum logic [1:0] {
        RET_NONE = 2'd0,
        RET_LO   = 2'd1,
        RET_HI   = 2'd2,
        RET_OFF  = 2'd3
    } ret_e;

endpackage

// File: rtl/pvf_wave_table.sv
module pvf_wave_table
    import pvf_pkg::*;
#(
    parameter int NUM_TBL = 32,
    parameter int NUM_CHR = 15,
    parameter int TW      = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  busy,
    input  logic                  wr_en,
    input  logic [SEL_W-1:0]      wr_tbl,
    input  logic [CODE_W-1:0]     wr_chr,
    input  logic [5+3*TW-1:0]     wr_data,
    output logic                  wr_ack,
    output logic                  wr_err,
    input  logic [SEL_W-1:0]      rd_tbl,
    input  logic [CODE_W-1:0]     rd_chr,
    output logic [5+3*TW-1:0]     rd_ent
);

    localparam int ENT_W = 5 + 3 * TW;
    localparam int DEPTH = NUM_TBL * NUM_CHR;
    localparam int AW    = $clog2(DEPTH);
    localparam logic [ENT_W-1:0] ENT_IDLE = {{(ENT_W-3){1'b0}}, ACT_SKIP};

    typedef struct packed {
        logic ack;
        logic err;
    } host_t;

    host_t              h_d, h_q;
    logic [ENT_W-1:0]   mem_q [DEPTH];
    logic               wr_ok, wr_do, rd_ok;
    logic [AW-1:0]      waddr, raddr;

    function automatic logic in_range(logic [SEL_W-1:0] sel, logic [CODE_W-1:0] code);
        return (int'(sel) < NUM_TBL) && (int'(code) < NUM_CHR);
    endfunction

    function automatic logic [AW-1:0] addr_of(logic [SEL_W-1:0] sel, logic [CODE_W-1:0] code);
        return AW'(int'(sel) * NUM_CHR + int'(code));
    endfunction

    always_comb begin
        wr_ok  = in_range(wr_tbl, wr_chr);
        wr_do  = wr_en && !busy && wr_ok;
        waddr  = addr_of(wr_tbl, wr_chr);
        rd_ok  = in_range(rd_tbl, rd_chr);
        raddr  = addr_of(rd_tbl, rd_chr);
        rd_ent = rd_ok ? mem_q[raddr] : ENT_IDLE;
        h_d.ack = wr_en;
        h_d.err = wr_en && (busy || !wr_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= ENT_IDLE;
            end
        end else if (wr_do) begin
            mem_q[waddr] <= wr_data;
        end
    end

    assign wr_ack = h_q.ack;
    assign wr_err = h_q.err;

    // R2: every write request is answered on the next cycle
    a_r2_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> wr_ack);

    // R3: a write while the pattern is busy is always refused
    a_r3_busy_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && busy) |=> (wr_ack && wr_err));

endmodule

// File: rtl/pvf_period_seq.sv
module pvf_period_seq #(
    parameter int TW    = 8,
    parameter int IDX_W = 16,
    parameter int ENT_W = 5 + 3 * TW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [TW-1:0]      period_len,
    input  logic [ENT_W-1:0]   rd_ent,
    output logic               vec_take,
    output logic               active,
    output logic [TW-1:0]      cnt,
    output logic [ENT_W-1:0]   ent,
    output logic [IDX_W-1:0]   cur_idx
);

    localparam logic [TW-1:0]    T_ONE = TW'(1);
    localparam logic [IDX_W-1:0] I_ONE = IDX_W'(1);

    typedef struct packed {
        logic               active;
        logic [TW-1:0]      cnt;
        logic [TW-1:0]      len;
        logic [ENT_W-1:0]   ent;
        logic [IDX_W-1:0]   cur;
        logic [IDX_W-1:0]   nxt;
    } seq_t;

    seq_t s_d, s_q;
    logic last_tick;
    logic take;

    always_comb begin
        last_tick = s_q.active && (s_q.cnt == s_q.len - T_ONE);
        take      = run && (!s_q.active || last_tick);
        s_d       = s_q;
        if (take) begin
            s_d.active = 1'b1;
            s_d.cnt    = '0;
            s_d.len    = (period_len == '0) ? T_ONE : period_len;
            s_d.ent    = rd_ent;
            s_d.cur    = s_q.active ? s_q.nxt : '0;
            s_d.nxt    = (s_q.active ? s_q.nxt : '0) + I_ONE;
        end else if (last_tick) begin
            s_d.active = 1'b0;
        end else if (s_q.active) begin
            s_d.cnt = s_q.cnt + T_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.len <= T_ONE;
        end else begin
            s_q <= s_d;
        end
    end

    assign vec_take = take;
    assign active   = s_q.active;
    assign cnt      = s_q.cnt;
    assign ent      = s_q.ent;
    assign cur_idx  = s_q.cur;

    // R4: the tick count never leaves the latched period
    a_r4_cnt_in_period: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.active |-> (s_q.cnt < s_q.len));

    // R4: a consumed vector always starts at tick 0
    a_r4_take_starts: assert property (@(posedge clk) disable iff (!rst_n)
        vec_take |=> (active && cnt == '0));

    // R11: the first vector after idle gets index 0
    a_r11_first_index: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_take && !active) |=> (cur_idx == '0));

endmodule

// File: rtl/pvf_pin_engine.sv
module pvf_pin_engine
    import pvf_pkg::*;
#(
    parameter int TW    = 8,
    parameter int IDX_W = 16,
    parameter int ENT_W = 5 + 3 * TW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active,
    input  logic [TW-1:0]      cnt,
    input  logic [ENT_W-1:0]   ent,
    input  logic [IDX_W-1:0]   cur_idx,
    input  logic               pin_in,
    input  logic               pin_hiz,
    output logic               pin_out,
    output logic               pin_oe,
    output logic               res_valid,
    output logic               res_fail,
    output logic [IDX_W-1:0]   res_index
);

    typedef struct packed {
        logic [TW-1:0] strb;
        logic [TW-1:0] e2;
        logic [TW-1:0] e1;
        logic [1:0]    ret;
        logic [2:0]    act;
    } ent_t;

    typedef struct packed {
        logic             out;
        logic             oe;
        logic             rv;
        logic             rf;
        logic [IDX_W-1:0] ridx;
    } pin_t;

    pin_t p_d, p_q;
    ent_t e;
    logic drive, e1_hit, e2_hit, st_hit, miss;

    always_comb begin
        e      = ent;
        drive  = (e.act[2] == 1'b0);
        e1_hit = active && drive && (cnt == e.e1);
        e2_hit = active && drive && (e.ret != RET_NONE) && (cnt == e.e2);
        st_hit = active && (cnt == e.strb);

        case (e.act)
            ACT_CMP_LO: miss = pin_hiz || pin_in;
            ACT_CMP_HI: miss = pin_hiz || !pin_in;
            ACT_CMP_Z:  miss = !pin_hiz;
            default:    miss = 1'b0;
        endcase

        p_d = p_q;
        if (e1_hit) begin
            case (e.act)
                ACT_LO:   begin p_d.out = 1'b0; p_d.oe = 1'b1; end
                ACT_HI:   begin p_d.out = 1'b1; p_d.oe = 1'b1; end
                ACT_PREV: p_d.oe = 1'b1;
                default:  p_d.oe = 1'b0;
            endcase
        end
        if (e2_hit) begin
            case (e.ret)
                RET_LO:  begin p_d.out = 1'b0; p_d.oe = 1'b1; end
                RET_HI:  begin p_d.out = 1'b1; p_d.oe = 1'b1; end
                default: p_d.oe = 1'b0;
            endcase
        end

        p_d.rv = st_hit;
        p_d.rf = st_hit && miss;
        if (st_hit) begin
            p_d.ridx = cur_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign pin_out   = p_q.out;
    assign pin_oe    = p_q.oe;
    assign res_valid = p_q.rv;
    assign res_fail  = p_q.rf;
    assign res_index = p_q.ridx;

    // R7: stop forcing releases the driver unless a return edge re-drives
    a_r7_off_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (e1_hit && e.act == ACT_OFF && !e2_hit) |=> !pin_oe);

    // R6: force previous enables the driver and keeps the driven value
    a_r6_prev_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (e1_hit && e.act == ACT_PREV && !e2_hit) |=> (pin_oe && $stable(pin_out)));

    // R10: a don't-compare strobe reports a pass
    a_r10_skip_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (st_hit && e.act == ACT_SKIP) |=> (res_valid && !res_fail));

    // R11: a result carries the index of the period that strobed
    a_r11_index_tag: assert property (@(posedge clk) disable iff (!rst_n)
        st_hit |=> (res_valid && res_index == $past(cur_idx)));

endmodule

// File: rtl/pin_vec_formatter.sv
module pin_vec_formatter
    import pvf_pkg::*;
#(
    parameter int NUM_TBL = 32,
    parameter int NUM_CHR = 15,
    parameter int TW      = 8,
    parameter int IDX_W   = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [SEL_W-1:0]      wr_tbl,
    input  logic [CODE_W-1:0]     wr_chr,
    input  logic [5+3*TW-1:0]     wr_data,
    output logic                  wr_ack,
    output logic                  wr_err,
    input  logic                  run,
    input  logic [TW-1:0]         period_len,
    input  logic [SEL_W-1:0]      vec_tbl,
    input  logic [CODE_W-1:0]     vec_chr,
    output logic                  vec_take,
    input  logic                  pin_in,
    input  logic                  pin_hiz,
    output logic                  pin_out,
    output logic                  pin_oe,
    output logic                  res_valid,
    output logic                  res_fail,
    output logic [IDX_W-1:0]      res_index
);

    localparam int ENT_W = 5 + 3 * TW;

    logic               active;
    logic [TW-1:0]      cnt;
    logic [ENT_W-1:0]   rd_ent;
    logic [ENT_W-1:0]   ent;
    logic [IDX_W-1:0]   cur_idx;
    logic               busy;

    assign busy = active || run;

    pvf_wave_table #(
        .NUM_TBL (NUM_TBL),
        .NUM_CHR (NUM_CHR),
        .TW      (TW)
    ) i_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy    (busy),
        .wr_en   (wr_en),
        .wr_tbl  (wr_tbl),
        .wr_chr  (wr_chr),
        .wr_data (wr_data),
        .wr_ack  (wr_ack),
        .wr_err  (wr_err),
        .rd_tbl  (vec_tbl),
        .rd_chr  (vec_chr),
        .rd_ent  (rd_ent)
    );

    pvf_period_seq #(
        .TW    (TW),
        .IDX_W (IDX_W),
        .ENT_W (ENT_W)
    ) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .period_len (period_len),
        .rd_ent     (rd_ent),
        .vec_take   (vec_take),
        .active     (active),
        .cnt        (cnt),
        .ent        (ent),
        .cur_idx    (cur_idx)
    );

    pvf_pin_engine #(
        .TW    (TW),
        .IDX_W (IDX_W),
        .ENT_W (ENT_W)
    ) i_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .cnt       (cnt),
        .ent       (ent),
        .cur_idx   (cur_idx),
        .pin_in    (pin_in),
        .pin_hiz   (pin_hiz),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .res_valid (res_valid),
        .res_fail  (res_fail),
        .res_index (res_index)
    );

endmodule

// File: tb/test_pin_vec_formatter.sv
module test_pin_vec_formatter;

    localparam int NT = 4;
    localparam int NC = 15;
    localparam int TW = 6;
    localparam int IW = 8;
    localparam int EW = 5 + 3 * TW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic           wr_en = 1'b0;
    logic [4:0]     wr_tbl = '0;
    logic [3:0]     wr_chr = '0;
    logic [EW-1:0]  wr_data = '0;
    logic           wr_ack, wr_err;
    logic           run = 1'b0;
    logic [TW-1:0]  period_len = '0;
    logic [4:0]     vec_tbl = '0;
    logic [3:0]     vec_chr = '0;
    logic           vec_take;
    logic           inj_inv = 1'b0;
    logic           inj_z = 1'b0;
    logic           pin_in, pin_hiz, pin_out, pin_oe;
    logic           res_valid, res_fail;
    logic [IW-1:0]  res_index;

    assign pin_in  = pin_out ^ inj_inv;
    assign pin_hiz = ~pin_oe | inj_z;

    pin_vec_formatter #(
        .NUM_TBL (NT),
        .NUM_CHR (NC),
        .TW      (TW),
        .IDX_W   (IW)
    ) i_pin_vec_formatter (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_tbl     (wr_tbl),
        .wr_chr     (wr_chr),
        .wr_data    (wr_data),
        .wr_ack     (wr_ack),
        .wr_err     (wr_err),
        .run        (run),
        .period_len (period_len),
        .vec_tbl    (vec_tbl),
        .vec_chr    (vec_chr),
        .vec_take   (vec_take),
        .pin_in     (pin_in),
        .pin_hiz    (pin_hiz),
        .pin_out    (pin_out),
        .pin_oe     (pin_oe),
        .res_valid  (res_valid),
        .res_fail   (res_fail),
        .res_index  (res_index)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_req = "R12";

    // behavioural reference state
    logic [EW-1:0] m_tab [NT*NC];
    logic [EW-1:0] m_ent;
    int m_act = 0, m_cnt = 0, m_len = 1, m_cur = 0, m_nxt = 0;
    int m_out = 0, m_oe = 0, m_rv = 0, m_rf = 0, m_ridx = 0, m_ack = 0, m_err = 0;

    int q_tbl[$], q_chr[$], q_len[$];

    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_fail++;
            $display("FAIL R4 watchdog: got %0d cycles expected finish", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    function automatic logic [EW-1:0] mk(int a, int r, int e1, int e2, int st);
        return {TW'(st), TW'(e2), TW'(e1), 2'(r), 3'(a)};
    endfunction

    task automatic chk(string nm, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", cur_req, nm, got, exp);
        end
    endtask

    function automatic int model_take(int run_i);
        return (run_i != 0 && (m_act == 0 || m_cnt == m_len - 1)) ? 1 : 0;
    endfunction

    task automatic model_step(int run_i, int plen, int vt, int vc, int we, int wt, int wc,
                              logic [EW-1:0] wd, int pi, int ph, int tk);
        int a, r, e1, e2, st;
        a  = int'(m_ent[2:0]);
        r  = int'(m_ent[4:3]);
        e1 = int'(m_ent[5 +: TW]);
        e2 = int'(m_ent[5+TW +: TW]);
        st = int'(m_ent[5+2*TW +: TW]);
        m_rv = 0;
        m_rf = 0;
        if (m_act != 0) begin
            if (a < 4 && m_cnt == e1) begin
                if (a == 0) begin m_out = 0; m_oe = 1; end
                else if (a == 1) begin m_out = 1; m_oe = 1; end
                else if (a == 2) m_oe = 1;
                else m_oe = 0;
            end
            if (a < 4 && r != 0 && m_cnt == e2) begin
                if (r == 1) begin m_out = 0; m_oe = 1; end
                else if (r == 2) begin m_out = 1; m_oe = 1; end
                else m_oe = 0;
            end
            if (m_cnt == st) begin
                m_rv = 1;
                m_ridx = m_cur;
                if (a == 4) m_rf = (ph != 0 || pi != 0) ? 1 : 0;
                else if (a == 5) m_rf = (ph != 0 || pi == 0) ? 1 : 0;
                else if (a == 6) m_rf = (ph == 0) ? 1 : 0;
            end
        end
        m_ack = we;
        m_err = (we != 0 && (m_act != 0 || run_i != 0 || wt >= NT || wc >= NC)) ? 1 : 0;
        if (tk != 0) begin
            m_ent = (vt < NT && vc < NC) ? m_tab[vt*NC + vc] : EW'(7);
            m_cur = ((m_act != 0) ? m_nxt : 0) % 256;
            m_nxt = m_cur + 1;
            m_len = (plen == 0) ? 1 : plen;
            m_cnt = 0;
            m_act = 1;
        end else if (m_act != 0 && m_cnt == m_len - 1) begin
            m_act = 0;
        end else if (m_act != 0) begin
            m_cnt++;
        end
        if (we != 0 && m_err == 0) m_tab[wt*NC + wc] = wd;
    endtask

    // one clock: inputs are already set after the falling edge
    task automatic tick(output int took);
        int tk, pi, ph;
        #1;
        tk = model_take(int'(run));
        chk("vec_take", int'(vec_take), tk);
        pi = int'(pin_in);
        ph = int'(pin_hiz);
        @(posedge clk);
        model_step(int'(run), int'(period_len), int'(vec_tbl), int'(vec_chr), int'(wr_en),
                   int'(wr_tbl), int'(wr_chr), wr_data, pi, ph, tk);
        @(negedge clk);
        chk("pin_out", int'(pin_out), m_out);
        chk("pin_oe", int'(pin_oe), m_oe);
        chk("res_valid", int'(res_valid), m_rv);
        if (m_rv != 0) begin
            chk("res_fail", int'(res_fail), m_rf);
            chk("res_index", int'(res_index), m_ridx);
        end
        chk("wr_ack", int'(wr_ack), m_ack);
        if (m_ack != 0) chk("wr_err", int'(wr_err), m_err);
        took = tk;
    endtask

    task automatic host_wr(int t, int c, logic [EW-1:0] d);
        int tk;
        wr_en = 1'b1;
        wr_tbl = 5'(t);
        wr_chr = 4'(c);
        wr_data = d;
        tick(tk);
        wr_en = 1'b0;
        tick(tk);
    endtask

    task automatic add(int t, int c, int l);
        q_tbl.push_back(t);
        q_chr.push_back(c);
        q_len.push_back(l);
    endtask

    // play queued vectors; optional busy write at cycle wr_at; optional random pin faults
    task automatic play(string req, int wr_at, int rnd);
        int i, n, tk;
        cur_req = req;
        i = 0;
        n = 0;
        while (i < q_tbl.size()) begin
            run = 1'b1;
            vec_tbl = 5'(q_tbl[i]);
            vec_chr = 4'(q_chr[i]);
            period_len = TW'(q_len[i]);
            wr_en = (n == wr_at);
            wr_tbl = 5'd0;
            wr_chr = 4'd1;
            wr_data = mk(1, 0, 0, 0, 0);
            if (rnd != 0) begin
                inj_inv = ($urandom_range(0, 3) == 0);
                inj_z = ($urandom_range(0, 5) == 0);
            end
            tick(tk);
            if (tk != 0) i++;
            n++;
        end
        run = 1'b0;
        wr_en = 1'b0;
        while (m_act != 0) tick(tk);
        inj_inv = 1'b0;
        inj_z = 1'b0;
        for (int k = 0; k < 2; k++) tick(tk);
        q_tbl.delete();
        q_chr.delete();
        q_len.delete();
    endtask

    initial begin
        int tk;
        for (int k = 0; k < NT*NC; k++) m_tab[k] = EW'(7);
        m_ent = EW'(7);
        repeat (3) @(negedge clk);
        cur_req = "R12";
        chk("reset pin_oe", int'(pin_oe), 0);
        chk("reset pin_out", int'(pin_out), 0);
        chk("reset res_valid", int'(res_valid), 0);
        chk("reset wr_ack", int'(wr_ack), 0);
        chk("reset vec_take", int'(vec_take), 0);
        rst_n = 1'b1;
        tick(tk);

        // R1: out-of-range select and code behave as don't-compare
        add(5, 0, 4); add(0, 15, 3); add(3, 14, 2);
        play("R1", -1, 0);

        // R2: table programming and refused addresses
        cur_req = "R2";
        host_wr(0, 0, mk(1, 1, 2, 5, 7));
        host_wr(0, 1, mk(0, 0, 1, 0, 6));
        host_wr(0, 2, mk(2, 0, 3, 0, 0));
        host_wr(0, 3, mk(3, 0, 3, 0, 0));
        host_wr(0, 4, mk(5, 0, 0, 0, 4));
        host_wr(0, 5, mk(4, 0, 0, 0, 4));
        host_wr(0, 6, mk(6, 0, 0, 0, 2));
        host_wr(0, 7, mk(7, 0, 0, 0, 1));
        host_wr(0, 8, mk(1, 3, 3, 3, 5));
        host_wr(0, 9, mk(1, 1, 40, 50, 45));
        host_wr(0, 10, mk(1, 0, 0, 0, 3));
        host_wr(0, 11, mk(0, 2, 2, 4, 5));
        host_wr(1, 0, mk(1, 1, 6, 1, 2));
        host_wr(1, 4, mk(5, 0, 0, 0, 0));
        host_wr(1, 5, mk(4, 0, 0, 0, 3));
        host_wr(3, 14, mk(4, 0, 0, 0, 9));
        host_wr(4, 0, mk(1, 0, 0, 0, 0));
        host_wr(0, 15, mk(1, 0, 0, 0, 0));

        // R6: force low / high / previous
        add(0, 1, 8); add(0, 10, 8); add(0, 2, 8); add(0, 1, 8); add(0, 2, 8);
        play("R6", -1, 0);

        // R8: return states, equal edges, return before data edge
        add(0, 0, 8); add(0, 8, 8); add(1, 0, 8); add(0, 11, 8); add(0, 4, 8);
        play("R8", -1, 0);

        // R7: stop forcing then re-drive the previous value
        add(0, 10, 8); add(0, 3, 8); add(0, 2, 8); add(0, 3, 8);
        play("R7", -1, 0);

        // R9: offsets at or past the period end
        add(0, 10, 8); add(0, 9, 8); add(0, 1, 8); add(0, 0, 4); add(0, 0, 6); add(0, 0, 7);
        play("R9", -1, 0);

        // R10: compare outcomes with a clean pin
        add(0, 10, 8); add(0, 4, 8); add(0, 1, 8); add(0, 5, 8);
        add(0, 3, 8); add(0, 6, 8); add(0, 7, 8); add(3, 14, 12);
        play("R10", -1, 0);
        // R10: inverted pin value makes level compares fail
        inj_inv = 1'b1;
        add(0, 10, 8); add(0, 4, 8); add(0, 5, 8); add(0, 7, 8);
        play("R10", -1, 0);
        // R10: forced high impedance
        inj_z = 1'b1;
        add(0, 10, 8); add(0, 4, 8); add(0, 6, 8); add(0, 5, 8);
        play("R10", -1, 0);

        // R4: zero and single-tick periods back to back
        add(1, 4, 1); add(1, 4, 0); add(0, 10, 1); add(1, 5, 4); add(0, 7, 0); add(0, 1, 2);
        play("R4", -1, 0);

        // R5: offsets moving every period through character and table changes
        add(0, 0, 9); add(1, 0, 9); add(0, 11, 5); add(0, 0, 12); add(1, 0, 7); add(0, 8, 4);
        play("R5", -1, 0);

        // R3: write during a run is refused; entry keeps its force-low behaviour
        add(0, 10, 6); add(0, 1, 6); add(0, 4, 6); add(0, 1, 6);
        play("R3", 3, 0);
        add(0, 10, 6); add(0, 1, 8);
        play("R3", -1, 0);

        // R11: index restarts at 0 after idle, then counts
        add(0, 7, 3); add(0, 7, 3); add(0, 4, 5);
        play("R11", -1, 0);

        // R5: long mixed run with random pin faults
        for (int k = 0; k < 160; k++) begin
            int t;
            t = $urandom_range(0, 4);
            add((t == 4) ? 5 : ((t == 2) ? 3 : t), $urandom_range(0, 15), $urandom_range(0, 12));
        end
        play("R5", -1, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule